// File: doc/BRIEF.md
# Memory-Reference Execution Unit

This block carries out the execute phase of the seven instructions of a 16-bit accumulator machine that take an operand address: bitwise AND, add, load, store, unconditional jump, jump-to-subroutine with the return address saved in memory, and increment-memory-and-skip-if-zero. The surrounding sequencer fetches and decodes the instruction and resolves any indirect address. It then presents a one-hot opcode vector, the current timing step and the operand address register to this unit.

The unit owns the accumulator, the carry flag and the data register. It drives the single memory port: the address, the write data and the write strobe. It also issues load and increment requests for the program counter and the address register, which live outside the block. On the last step of each instruction it raises a request to clear the step counter, so the sequencer can return to fetch.

Memory reads are taken to be combinational: `mem_rdata` must hold the word at `ar_in` during the same cycle. All register updates happen on the rising clock edge. All control outputs are combinational in the opcode, the step and the current register contents.

Top module: `mref_exec_unit`

## Requirements
- R1: After an asynchronous active-low reset, `acc`, `e_flag` and `dr` are all zero.
- R2: `op_sel` bit k selects opcode k: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ. `step` carries the timing step number, with 3 to 6 meaning T3 to T6. At T3 every opcode raises no control output and changes no register.
- R3: For AND and LDA, DR takes the memory word at T4. At T5 AC becomes AC AND DR (AND) or DR (LDA), and `sc_clear` is raised.
- R4: For ADD, DR takes the memory word at T4. At T5 AC becomes the low 16 bits of AC+DR and E takes the carry out of bit 15, with `sc_clear` raised.
- R5: For STA at T4, `mem_we` is raised with `mem_wdata` equal to AC, and `sc_clear` is raised.
- R6: For BUN at T4, `pc_load` is raised with `pc_load_val` equal to `ar_in`, and `sc_clear` is raised.
- R7: For BSA at T4, `mem_we` is raised with `pc_in` zero-extended as the write data, and `ar_inc` is raised. At T5 `pc_load` is raised with `pc_load_val` equal to `ar_in`, and `sc_clear` is raised.
- R8: For ISZ, DR takes the memory word at T4 and increments at T5. At T6 `mem_we` writes DR, and `pc_inc` is raised exactly when DR is zero, with `sc_clear` raised.
- R9: `sc_clear` is high only on the final step of the selected opcode (T4 for STA and BUN, T5 for AND, ADD, LDA and BSA, T6 for ISZ). Steps outside an opcode's schedule do nothing.
- R10: An `op_sel` with zero or more than one bit set raises no control output and leaves AC, E and DR unchanged.
- R11: `mem_addr` always equals `ar_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 7 | One-hot decoded opcode |
| step | input | 3 | Current timing step number |
| ar_in | input | ADDR_W | Operand address register value |
| pc_in | input | ADDR_W | Program counter value |
| mem_rdata | input | DATA_W | Memory word at `ar_in` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| pc_load | output | 1 | Load the program counter with `pc_load_val` |
| pc_load_val | output | ADDR_W | Value to load into the program counter |
| pc_inc | output | 1 | Increment the program counter (skip) |
| ar_inc | output | 1 | Increment the address register |
| sc_clear | output | 1 | Clear the step counter; the instruction is done |
| acc | output | DATA_W | Accumulator |
| e_flag | output | 1 | Carry flag |
| dr | output | DATA_W | Data register |

## Verification
A wrong register value inside this block cannot hide. The accumulator, carry flag and data register are ports, and each one is compared one cycle after the step that should have written it. A bad data register also shows up one step later: in the accumulator for AND, ADD and LDA, and in the memory word and the skip decision for ISZ. A decode fault shows as a missing, early or extra `sc_clear` or write strobe in the very step where it occurs. The bench checks every step of every instruction, so the step count of each opcode is pinned.

// File: rtl/mref_pkg.sv
package mref_pkg;

   localparam int NUM_OPS = 7;

   localparam logic [2:0] STEP_T3 = 3'd3;
   localparam logic [2:0] STEP_T4 = 3'd4;
   localparam logic [2:0] STEP_T5 = 3'd5;
   localparam logic [2:0] STEP_T6 = 3'd6;

   typedef enum logic [2:0] {
      OP_AND = 3'd0,
      OP_ADD = 3'd1,
      OP_LDA = 3'd2,
      OP_STA = 3'd3,
      OP_BUN = 3'd4,
      OP_BSA = 3'd5,
      OP_ISZ = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      AC_HOLD,
      AC_AND,
      AC_ADD,
      AC_LOAD
   } ac_fn_e;

   typedef enum logic [1:0] {
      DR_HOLD,
      DR_MEM,
      DR_INC
   } dr_fn_e;

   typedef enum logic [1:0] {
      WS_NONE,
      WS_AC,
      WS_PC,
      WS_DR
   } wsrc_e;

   typedef struct packed {
      ac_fn_e ac_fn;
      dr_fn_e dr_fn;
      wsrc_e  wsrc;
      logic   pc_from_ar;
      logic   ar_inc;
      logic   skip_test;
      logic   sc_clr;
   } ctrl_t;

   localparam ctrl_t CTRL_IDLE = '{
      ac_fn: AC_HOLD, dr_fn: DR_HOLD, wsrc: WS_NONE,
      pc_from_ar: 1'b0, ar_inc: 1'b0, skip_test: 1'b0, sc_clr: 1'b0
   };

endpackage

// File: rtl/mref_decode.sv
module mref_decode
   import mref_pkg::*;
#(
   parameter int N_OPS = NUM_OPS
) (
   input  logic [N_OPS-1:0] op_sel,
   input  logic [2:0]       step,
   output ctrl_t            ctrl
);

   localparam int IDX_W = (N_OPS > 1) ? $clog2(N_OPS) : 1;

   if (N_OPS != NUM_OPS) begin : g_bad_ops
      $error("mref_decode: N_OPS must equal the opcode count");
   end

   logic             sel_ok;
   logic [IDX_W-1:0] sel_idx;

   assign sel_ok = $onehot(op_sel);

   always_comb begin
      sel_idx = '0;
      for (int k = 0; k < N_OPS; k++) begin
         if (op_sel[k]) sel_idx = IDX_W'(k);
      end
   end

   always_comb begin
      ctrl = CTRL_IDLE;
      if (sel_ok) begin
         unique case (op_e'(sel_idx))
            OP_AND: begin
               if (step == STEP_T4) ctrl.dr_fn = DR_MEM;
               if (step == STEP_T5) begin
                  ctrl.ac_fn  = AC_AND;
                  ctrl.sc_clr = 1'b1;
               end
            end
            OP_ADD: begin
               if (step == STEP_T4) ctrl.dr_fn = DR_MEM;
               if (step == STEP_T5) begin
                  ctrl.ac_fn  = AC_ADD;
                  ctrl.sc_clr = 1'b1;
               end
            end
            OP_LDA: begin
               if (step == STEP_T4) ctrl.dr_fn = DR_MEM;
               if (step == STEP_T5) begin
                  ctrl.ac_fn  = AC_LOAD;
                  ctrl.sc_clr = 1'b1;
               end
            end
            OP_STA: begin
               if (step == STEP_T4) begin
                  ctrl.wsrc   = WS_AC;
                  ctrl.sc_clr = 1'b1;
               end
            end
            OP_BUN: begin
               if (step == STEP_T4) begin
                  ctrl.pc_from_ar = 1'b1;
                  ctrl.sc_clr     = 1'b1;
               end
            end
            OP_BSA: begin
               if (step == STEP_T4) begin
                  ctrl.wsrc   = WS_PC;
                  ctrl.ar_inc = 1'b1;
               end
               if (step == STEP_T5) begin
                  ctrl.pc_from_ar = 1'b1;
                  ctrl.sc_clr     = 1'b1;
               end
            end
            OP_ISZ: begin
               if (step == STEP_T4) ctrl.dr_fn = DR_MEM;
               if (step == STEP_T5) ctrl.dr_fn = DR_INC;
               if (step == STEP_T6) begin
                  ctrl.wsrc      = WS_DR;
                  ctrl.skip_test = 1'b1;
                  ctrl.sc_clr    = 1'b1;
               end
            end
            default: ctrl = CTRL_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mref_adder.sv
module mref_adder #(
   parameter int DATA_W      = 16,
   parameter int ADDER_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] sum,
   output logic              cout
);

   if (DATA_W < 2) begin : g_bad_w
      $error("mref_adder: DATA_W must be at least 2");
   end
   if (ADDER_STYLE != 0 && ADDER_STYLE != 1) begin : g_bad_style
      $error("mref_adder: ADDER_STYLE must be 0 or 1");
   end

   if (ADDER_STYLE == 0) begin : g_infer
      assign {cout, sum} = {1'b0, a} + {1'b0, b};
   end else begin : g_ripple
      logic [DATA_W:0] carry;
      assign carry[0] = 1'b0;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ carry[i];
         assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
      end
      assign cout = carry[DATA_W];
   end

endmodule

// File: rtl/mref_regs.sv
module mref_regs
   import mref_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ac_fn_e            ac_fn,
   input  dr_fn_e            dr_fn,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [DATA_W-1:0] add_sum,
   input  logic              add_cout,
   output logic [DATA_W-1:0] acc_q,
   output logic              e_q,
   output logic [DATA_W-1:0] dr_q
);

   logic [DATA_W-1:0] acc_d;
   logic              e_d;
   logic [DATA_W-1:0] dr_d;

   always_comb begin
      acc_d = acc_q;
      e_d   = e_q;
      unique case (ac_fn)
         AC_AND:  acc_d = acc_q & dr_q;
         AC_ADD: begin
            acc_d = add_sum;
            e_d   = add_cout;
         end
         AC_LOAD: acc_d = dr_q;
         default: acc_d = acc_q;
      endcase
   end

   always_comb begin
      unique case (dr_fn)
         DR_MEM:  dr_d = mem_rdata;
         DR_INC:  dr_d = dr_q + DATA_W'(1);
         default: dr_d = dr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         e_q   <= 1'b0;
         dr_q  <= '0;
      end else begin
         acc_q <= acc_d;
         e_q   <= e_d;
         dr_q  <= dr_d;
      end
   end

endmodule

// File: rtl/mref_exec_unit.sv
module mref_exec_unit
   import mref_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 12,
   parameter int ADDER_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [6:0]        op_sel,
   input  logic [2:0]        step,
   input  logic [ADDR_W-1:0] ar_in,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              pc_load,
   output logic [ADDR_W-1:0] pc_load_val,
   output logic              pc_inc,
   output logic              ar_inc,
   output logic              sc_clear,
   output logic [DATA_W-1:0] acc,
   output logic              e_flag,
   output logic [DATA_W-1:0] dr
);

   localparam int PAD_W = DATA_W - ADDR_W;

   if (ADDR_W < 1 || PAD_W < 0) begin : g_bad_widths
      $error("mref_exec_unit: ADDR_W must be between 1 and DATA_W");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] add_sum;
   logic              add_cout;
   logic [DATA_W-1:0] pc_ext;

   mref_decode #(.N_OPS(NUM_OPS)) dec_i (
      .op_sel (op_sel),
      .step   (step),
      .ctrl   (ctrl)
   );

   mref_adder #(.DATA_W(DATA_W), .ADDER_STYLE(ADDER_STYLE)) add_i (
      .a    (acc),
      .b    (dr),
      .sum  (add_sum),
      .cout (add_cout)
   );

   mref_regs #(.DATA_W(DATA_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ac_fn     (ctrl.ac_fn),
      .dr_fn     (ctrl.dr_fn),
      .mem_rdata (mem_rdata),
      .add_sum   (add_sum),
      .add_cout  (add_cout),
      .acc_q     (acc),
      .e_q       (e_flag),
      .dr_q      (dr)
   );

   if (PAD_W > 0) begin : g_pad
      assign pc_ext = {{PAD_W{1'b0}}, pc_in};
   end else begin : g_nopad
      assign pc_ext = DATA_W'(pc_in);
   end

   always_comb begin
      unique case (ctrl.wsrc)
         WS_AC:   mem_wdata = acc;
         WS_PC:   mem_wdata = pc_ext;
         WS_DR:   mem_wdata = dr;
         default: mem_wdata = '0;
      endcase
   end

   assign mem_addr    = ar_in;
   assign mem_we      = (ctrl.wsrc != WS_NONE);
   assign pc_load     = ctrl.pc_from_ar;
   assign pc_load_val = ar_in;
   assign pc_inc      = ctrl.skip_test && (dr == '0);
   assign ar_inc      = ctrl.ar_inc;
   assign sc_clear    = ctrl.sc_clr;

endmodule

// File: rtl/mref_exec_chk.sv
module mref_exec_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [6:0]        op_sel,
   input logic [2:0]        step,
   input logic [ADDR_W-1:0] ar_in,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_we,
   input logic              pc_load,
   input logic              pc_inc,
   input logic              ar_inc,
   input logic              sc_clear,
   input logic [DATA_W-1:0] acc,
   input logic              e_flag,
   input logic [DATA_W-1:0] dr
);

   logic dr_loads;
   assign dr_loads = (op_sel == 7'b0000001) || (op_sel == 7'b0000010) ||
                     (op_sel == 7'b0000100) || (op_sel == 7'b1000000);

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (acc == '0 && dr == '0 && e_flag == 1'b0);
      end
   end

   // R2
   t3_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd3) |-> !(mem_we || pc_load || pc_inc || ar_inc || sc_clear));

   // R4
   add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 7'b0000010 && step == 3'd5) |=>
      ({e_flag, acc} == ({1'b0, $past(acc)} + {1'b0, $past(dr)})));

   // R3
   dr_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dr_loads && step == 3'd4) |=> (dr == $past(mem_rdata)));

   // R8
   skip_only_isz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc |-> (op_sel == 7'b1000000 && step == 3'd6 && dr == '0));

   // R9
   write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (step == 3'd4 || step == 3'd6));

   // R10
   bad_sel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$onehot(op_sel) |-> !(mem_we || pc_load || pc_inc || ar_inc || sc_clear));

   // R10
   bad_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$onehot(op_sel) |=> ($stable(acc) && $stable(dr) && $stable(e_flag)));

   // R11
   addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_addr == ar_in);

endmodule

bind mref_exec_unit mref_exec_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_sel    (op_sel),
   .step      (step),
   .ar_in     (ar_in),
   .mem_rdata (mem_rdata),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .pc_load   (pc_load),
   .pc_inc    (pc_inc),
   .ar_inc    (ar_inc),
   .sc_clear  (sc_clear),
   .acc       (acc),
   .e_flag    (e_flag),
   .dr        (dr)
);

// File: tb/mref_exec_unit_tb_top.sv
module mref_exec_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [6:0]    op_sel = '0;
   logic [2:0]    step = 3'd0;
   logic [AW-1:0] ar_in = '0;
   logic [AW-1:0] pc_in = '0;
   logic [DW-1:0] mem_rdata = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we;
   logic          pc_load;
   logic [AW-1:0] pc_load_val;
   logic          pc_inc;
   logic          ar_inc;
   logic          sc_clear;
   logic [DW-1:0] acc;
   logic          e_flag;
   logic [DW-1:0] dr;

   always #(CLK_PERIOD/2) clk = ~clk;

   mref_exec_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .step(step),
      .ar_in(ar_in), .pc_in(pc_in), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .pc_load(pc_load), .pc_load_val(pc_load_val), .pc_inc(pc_inc),
      .ar_inc(ar_inc), .sc_clear(sc_clear), .acc(acc), .e_flag(e_flag), .dr(dr)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [DW-1:0] mem [0:63];
   logic [AW-1:0] b_pc, b_ar;
   logic [DW-1:0] m_acc, m_dr;
   logic          m_e;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One timing step: drive, sample controls before the edge, then play the datapath.
   task automatic do_step(input logic [6:0] ops, input int t, output logic sc);
      logic we, pl, pi, ai;
      logic [DW-1:0] wd;
      logic [AW-1:0] pv;
      @(negedge clk);
      op_sel = ops; step = 3'(t); ar_in = b_ar; pc_in = b_pc;
      mem_rdata = mem[b_ar[5:0]];
      #1;
      chk("R11 mem_addr", 32'(mem_addr), 32'(b_ar));
      we = mem_we; wd = mem_wdata; pl = pc_load; pv = pc_load_val;
      pi = pc_inc; ai = ar_inc; sc = sc_clear;
      if (t == 3) chk("R2 T3 idle", {28'd0, we, pl, pi, ai | sc}, 32'd0);
      @(posedge clk);
      if (we) mem[b_ar[5:0]] = wd;
      if (pl) b_pc = pv;
      else if (pi) b_pc = b_pc + 1'b1;
      if (ai) b_ar = b_ar + 1'b1;
   endtask

   function automatic string req_of(input int k);
      case (k)
         0, 2: return "R3";
         1: return "R4";
         3: return "R5";
         4: return "R6";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic run_instr(input int k);
      int last;
      logic sc;
      logic [DW-1:0] m, x_acc, x_dr, x_memv;
      logic          x_e;
      logic [AW-1:0] x_pc, x_ar, x_addr;
      logic [16:0]   s;
      string r;
      r = req_of(k);
      m = mem[b_ar[5:0]];
      x_acc = m_acc; x_dr = m_dr; x_e = m_e; x_pc = b_pc; x_ar = b_ar;
      x_addr = b_ar; x_memv = m;
      case (k)
         0: begin x_dr = m; x_acc = m_acc & m; last = 5; end
         1: begin x_dr = m; s = {1'b0, m_acc} + {1'b0, m}; x_acc = s[15:0]; x_e = s[16]; last = 5; end
         2: begin x_dr = m; x_acc = m; last = 5; end
         3: begin x_memv = m_acc; last = 4; end
         4: begin x_pc = b_ar; last = 4; end
         5: begin x_memv = {4'd0, b_pc}; x_ar = b_ar + 1'b1; x_pc = b_ar + 1'b1; last = 5; end
         default: begin
            x_dr = m + 1'b1; x_memv = x_dr;
            if (x_dr == '0) x_pc = b_pc + 1'b1;
            last = 6;
         end
      endcase
      for (int t = 3; t <= last; t++) begin
         do_step(7'(1 << k), t, sc);
         chk({"R9 sc_clear ", r}, 32'(sc), 32'(t == last));
      end
      @(negedge clk);
      op_sel = '0;
      chk({r, " acc"}, 32'(acc), 32'(x_acc));
      chk({r, " e"}, 32'(e_flag), 32'(x_e));
      chk({r, " dr"}, 32'(dr), 32'(x_dr));
      chk({r, " pc"}, 32'(b_pc), 32'(x_pc));
      chk({r, " ar"}, 32'(b_ar), 32'(x_ar));
      chk({r, " mem"}, 32'(mem[x_addr[5:0]]), 32'(x_memv));
      m_acc = x_acc; m_dr = x_dr; m_e = x_e;
   endtask

   task automatic bad_sel(input logic [6:0] ops);
      logic sc;
      logic [AW-1:0] p0, a0;
      logic [DW-1:0] mv;
      p0 = b_pc; a0 = b_ar; mv = mem[b_ar[5:0]];
      for (int t = 3; t <= 6; t++) begin
         do_step(ops, t, sc);
         chk("R10 sc_clear", 32'(sc), 32'd0);
      end
      @(negedge clk);
      chk("R10 acc", 32'(acc), 32'(m_acc));
      chk("R10 dr", 32'(dr), 32'(m_dr));
      chk("R10 e", 32'(e_flag), 32'(m_e));
      chk("R10 pc/ar", {4'd0, p0, a0}, {4'd0, b_pc, b_ar});
      chk("R10 mem", 32'(mem[a0[5:0]]), 32'(mv));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h1d2c);
      for (int i = 0; i < 64; i++) mem[i] = 16'($urandom);
      b_pc = 12'h100; b_ar = 12'h010;
      m_acc = '0; m_dr = '0; m_e = 1'b0;
      #(CLK_PERIOD * 2 + 3);
      // R1
      chk("R1 acc", 32'(acc), 0);
      chk("R1 e", 32'(e_flag), 0);
      chk("R1 dr", 32'(dr), 0);
      @(negedge clk); rst_n = 1'b1;

      // directed corners
      b_ar = 12'd5; mem[5] = 16'hFFFF; run_instr(2);   // LDA FFFF
      b_ar = 12'd6; mem[6] = 16'h0001; run_instr(1);   // ADD carry out, R4
      b_ar = 12'd7; mem[7] = 16'hFFFF; run_instr(6);   // ISZ wraps, skip, R8
      b_ar = 12'd8; mem[8] = 16'h0004; run_instr(6);   // ISZ no skip, R8
      b_ar = 12'd9; b_pc = 12'hABC; run_instr(5);      // BSA, R7
      bad_sel(7'b0000000);
      bad_sel(7'b0010010);

      for (int n = 0; n < 400; n++) begin
         b_ar = AW'($urandom_range(0, 61));
         b_pc = AW'($urandom);
         case ($urandom_range(0, 9))
            0: mem[b_ar[5:0]] = 16'hFFFF;
            1: mem[b_ar[5:0]] = 16'h0000;
            default: mem[b_ar[5:0]] = 16'($urandom);
         endcase
         if (n % 50 == 49) bad_sel(7'($urandom) | 7'b0000011);
         else run_instr(int'($urandom_range(0, 6)));
      end
      finish_run();
   end

endmodule